// File: doc/BRIEF.md
# DRAM Refresh and Start-up Sequencer

This block keeps a fast page mode DRAM alive. Reset starts a wait for the supply and the array to settle. After the wait the block runs a short burst of refresh cycles and then raises `ready`. From then on it spreads the refresh cycles the device needs evenly over the refresh period. Each refresh is a CAS-before-RAS cycle. The DRAM keeps its own row counter, so the block drives no address.

The block shares the strobes with an access controller. It raises `ref_req` and waits for `ref_gnt`. It then owns the strobes, and shows this by holding `ref_drive` high until the cycle and its precharge are over. The controller may hold off the grant for a while. Requests that arrive in that time are counted, up to a parameter limit. They are then run back to back under one grant. Every timing window is given in nanoseconds and rounded up to whole clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high, `ref_req`, `ready` and `ref_drive` are 0, and `ras_n`, `cas_n` and `we_n` are 1.
- R2: After `rst` falls, `ref_req` stays low for a pause of PAUSE_NS rounded up to whole cycles (200 µs by default), and `ready` stays low. The first request appears within three cycles after the pause ends.
- R3: After the pause, exactly INIT_CYC (default 8) refresh cycles run before `ready` rises. Once high, `ready` stays high until reset.
- R4: The strobes move only while `ref_drive` is high. `ref_drive` rises only after `ref_req` and `ref_gnt` were both high on the previous cycle. While the grant is withheld, `ref_req` stays high and no refresh runs.
- R5: In each refresh cycle, `cas_n` falls first. `ras_n` falls SETUP cycles later, where SETUP is max(ceil(5 ns), ceil(10 ns)) and equals 3 at a 4 ns clock. `we_n` is 1 when `ras_n` falls.
- R6: `cas_n` stays low for ceil(10 ns) cycles after `ras_n` falls (3 at 4 ns). It then rises while `ras_n` is still low.
- R7: `ras_n` stays low for ceil(TRAS_NS) cycles (13 at 4 ns, 50 ns). It then stays high for ceil(TRP_NS) cycles (10 at 4 ns, 40 ns) before the next `cas_n` fall or the fall of `ref_drive`.
- R8: Once `ready` is high, a refresh comes due every REF_INTERVAL_CYC cycles. The first `ref_req` rises REF_INTERVAL_CYC+1 cycles after `ready` rises, and later rises are REF_INTERVAL_CYC apart.
- R9: By default REF_INTERVAL_CYC is the refresh period divided by the cycle count, divided by CLK_NS. The period and count are 32 ms / 2048 with REF_4K=0 and 64 ms / 4096 with REF_4K=1. This gives 3906 cycles at a 4 ns clock.
- R10: Refreshes that come due while the grant is withheld are counted up to MAX_BACKLOG; any beyond that are dropped. Once the grant arrives, all counted refreshes run back to back with `ref_drive` held high throughout. `ref_req` falls after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access controller hands over the strobes |
| ref_req | output | 1 | Sequencer asks for the strobes |
| ref_drive | output | 1 | Sequencer currently owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| ready | output | 1 | Start-up sequence finished |

## Verification
The bench runs the sequencer under three grant patterns. In the first, the grant is always on during the start-up burst. This separates the eight-cycle start-up from the periodic refresh. In the second, the grant is always on during steady refresh, which measures the spacing of requests. In the third, the grant is withheld for far longer than the backlog limit covers. This shows whether excess refreshes are dropped and whether the stored ones run as one uninterrupted burst. A scoreboard measures every refresh cycle against the expected set-up, hold, active and precharge lengths. A second instance with the 4K setting and default interval confirms the interval derived from the period and cycle count.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_PRE
  } cbr_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int INTERVAL = 3906
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = $clog2(INTERVAL + 1);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(INTERVAL - 1);
    end else if (en) begin
      if (cnt == '0) cnt <= W'(INTERVAL - 1);
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int MAX_BACKLOG = 8,
  parameter int INIT_CYC    = 8,
  localparam int PW         = $clog2(MAX_BACKLOG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_init,
  input  logic          tick,
  input  logic          done,
  output logic [PW-1:0] pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else if (load_init) begin
      pending <= PW'(INIT_CYC);
    end else begin
      unique case ({tick, done})
        2'b10: if (pending != PW'(MAX_BACKLOG)) pending <= pending + 1'b1;
        2'b01: if (pending != '0) pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end
endmodule

// File: rtl/cbr_cycle_fsm.sv
module cbr_cycle_fsm import dram_ref_pkg::*; #(
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 3,
  parameter int ACT_CYC   = 13,
  parameter int PRE_CYC   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic work_avail,
  input  logic more_work,
  input  logic gnt,
  output logic req,
  output logic drv,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cycle_done
);
  localparam int MAXC = max2(max2(SETUP_CYC, ACT_CYC), PRE_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  cbr_state_t   state;
  logic [CW-1:0] cnt;

  assign cycle_done = (state == ST_PRE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      req   <= 1'b0;
      drv   <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req && gnt) begin
            state <= ST_SETUP;
            cnt   <= CW'(SETUP_CYC - 1);
            drv   <= 1'b1;
            cas_n <= 1'b0;
            we_n  <= 1'b1;
          end else begin
            req <= work_avail;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_ACT;
            cnt   <= CW'(ACT_CYC - 1);
            ras_n <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACT: begin
          if (cnt == CW'(ACT_CYC - HOLD_CYC)) cas_n <= 1'b1;
          if (cnt == '0) begin
            state <= ST_PRE;
            cnt   <= CW'(PRE_CYC - 1);
            ras_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt == '0) begin
            if (more_work) begin
              state <= ST_SETUP;
              cnt   <= CW'(SETUP_CYC - 1);
              cas_n <= 1'b0;
            end else begin
              state <= ST_IDLE;
              req   <= 1'b0;
              drv   <= 1'b0;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq import dram_ref_pkg::*; #(
  parameter int CLK_NS           = 4,
  parameter bit REF_4K           = 1'b0,
  parameter int PAUSE_NS         = 200000,
  parameter int INIT_CYC         = 8,
  parameter int MAX_BACKLOG      = 8,
  parameter int REF_INTERVAL_CYC =
    (REF_4K ? 64000000 : 32000000) / ((REF_4K ? 4096 : 2048) * CLK_NS),
  parameter int CAS_LEAD_NS      = 5,
  parameter int WE_LEAD_NS       = 10,
  parameter int CAS_HOLD_NS      = 10,
  parameter int RAS_ACT_NS       = 50,
  parameter int RAS_PRE_NS       = 40,
  parameter int PRE_TO_CAS_NS    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_drive,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int PAUSE_CYC = ceil_div(PAUSE_NS, CLK_NS);
  localparam int SETUP_CYC = max2(ceil_div(CAS_LEAD_NS, CLK_NS), ceil_div(WE_LEAD_NS, CLK_NS));
  localparam int HOLD_CYC  = ceil_div(CAS_HOLD_NS, CLK_NS);
  localparam int ACT_CYC   = max2(ceil_div(RAS_ACT_NS, CLK_NS), HOLD_CYC + 1);
  localparam int PRE_CYC   = max2(ceil_div(RAS_PRE_NS, CLK_NS), ceil_div(PRE_TO_CAS_NS, CLK_NS));
  localparam int PAUSE_W   = $clog2(PAUSE_CYC + 1);
  localparam int PEND_W    = $clog2(MAX_BACKLOG + 1);

  logic [PAUSE_W-1:0] pause_cnt;
  logic               pause_done;
  logic               load_init;
  logic               tick;
  logic               cycle_done;
  logic [PEND_W-1:0]  pending;

  assign load_init = !pause_done && (pause_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_cnt  <= PAUSE_W'(PAUSE_CYC);
      pause_done <= 1'b0;
      ready      <= 1'b0;
    end else begin
      if (!pause_done) begin
        if (pause_cnt == '0) pause_done <= 1'b1;
        else                 pause_cnt  <= pause_cnt - 1'b1;
      end
      if (pause_done && !ready && cycle_done && (pending == PEND_W'(1)))
        ready <= 1'b1;
    end
  end

  refresh_tick_gen #(.INTERVAL(REF_INTERVAL_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (ready),
    .tick (tick)
  );

  refresh_backlog #(.MAX_BACKLOG(MAX_BACKLOG), .INIT_CYC(INIT_CYC)) u_backlog (
    .clk       (clk),
    .rst       (rst),
    .load_init (load_init),
    .tick      (tick),
    .done      (cycle_done),
    .pending   (pending)
  );

  cbr_cycle_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .ACT_CYC   (ACT_CYC),
    .PRE_CYC   (PRE_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .work_avail (pending != '0),
    .more_work  (pending > PEND_W'(1)),
    .gnt        (ref_gnt),
    .req        (ref_req),
    .drv        (ref_drive),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cycle_done (cycle_done)
  );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int PW   = 4,
  parameter int MAXB = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ref_drive,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          ready,
  input logic [PW-1:0] pending
);
  p_cas_leads_ras_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n) && we_n));

  p_cas_rises_under_ras_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cas_n) && ref_drive) |-> !ras_n);

  p_quiet_when_released_r4: assert property (@(posedge clk) disable iff (rst)
    !ref_drive |-> (ras_n && cas_n && we_n));

  p_grant_before_drive_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_drive) |-> ($past(ref_req) && $past(ref_gnt)));

  p_req_covers_drive_r4: assert property (@(posedge clk) disable iff (rst)
    ref_drive |-> ref_req);

  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    pending <= PW'(MAXB));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.PW(PEND_W), .MAXB(MAX_BACKLOG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_drive (ref_drive),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ready     (ready),
  .pending   (pending)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
  localparam int PAUSE = 100;
  localparam int INIT  = 8;
  localparam int MAXB  = 10;
  localparam int IVL   = 400;
  localparam int SETUP = 3;
  localparam int HOLD  = 3;
  localparam int TRAS  = 13;
  localparam int TRP   = 10;
  localparam int IVL4K = 3906;

  typedef struct { int s; int h; int a; } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gnt = 1'b1;
  logic req, drv, ras_n, cas_n, we_n, ready;
  logic req2, drv2, ras2, cas2, we2, ready2;

  int checks = 0, errors = 0, cyc = 0;
  int rst_cyc = 0, ready_cyc = -1, ready2_cyc = -1, req2_cyc = -1;
  int nref = 0, drv_falls = 0;
  int s_cnt = 0, h_cnt = 0, a_cnt = 0, p_cnt = 0;
  int req_rise[$];
  rec_t expq[$];
  logic ras_prev = 1'b1, req_prev = 1'b0, drv_prev = 1'b0, rdy_prev = 1'b0;
  logic req2_prev = 1'b0, rdy2_prev = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_seq #(.CLK_NS(4), .PAUSE_NS(PAUSE*4), .INIT_CYC(INIT),
                     .MAX_BACKLOG(MAXB), .REF_INTERVAL_CYC(IVL)) uut (
    .clk(clk), .rst(rst), .ref_gnt(gnt), .ref_req(req), .ref_drive(drv),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready));

  dram_refresh_seq #(.CLK_NS(4), .REF_4K(1'b1), .PAUSE_NS(40)) uut_4k (
    .clk(clk), .rst(rst), .ref_gnt(req2), .ref_req(req2), .ref_drive(drv2),
    .ras_n(ras2), .cas_n(cas2), .we_n(we2), .ready(ready2));

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic expect_refreshes(input int n);
    for (int i = 0; i < n; i++) expq.push_back('{s: SETUP, h: HOLD, a: TRAS});
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
    #1;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (drv && ras_n && !cas_n) s_cnt++;
      if (!ras_n && !cas_n)       h_cnt++;
      if (!ras_n)                 a_cnt++;
      if (drv && ras_n && cas_n)  p_cnt++;
      if (ras_prev && !ras_n)
        check(we_n == 1'b1, "R5 we_n high at row strobe fall", int'(we_n), 1);
      if (!ras_prev && ras_n) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4 unexpected refresh cycle", nref + 1, nref);
        end else begin
          rec_t e;
          e = expq.pop_front();
          check(s_cnt == e.s, "R5 column lead before row fall", s_cnt, e.s);
          check(h_cnt == e.h, "R6 column hold after row fall", h_cnt, e.h);
          check(a_cnt == e.a, "R7 row active length", a_cnt, e.a);
        end
        nref++;
        s_cnt = 0; h_cnt = 0; a_cnt = 0;
      end
      if (p_cnt > 0 && (!cas_n || !drv)) begin
        check(p_cnt == TRP, "R7 precharge length", p_cnt, TRP);
        p_cnt = 0;
      end
      if (!req_prev && req) req_rise.push_back(cyc);
      if (drv_prev && !drv) drv_falls++;
      if (!rdy_prev && ready) ready_cyc = cyc;
      if (!rdy2_prev && ready2) ready2_cyc = cyc;
      if (ready2 && !req2_prev && req2 && req2_cyc < 0) req2_cyc = cyc;
      ras_prev = ras_n; req_prev = req; drv_prev = drv; rdy_prev = ready;
      req2_prev = req2; rdy2_prev = ready2;
    end
  end

  initial begin
    int base, nb, df;
    repeat (5) @(negedge clk);
    #1;
    check({req, ready, drv} == 3'b000, "R1 req/ready/drive low in reset", int'({req, ready, drv}), 0);
    check({ras_n, cas_n, we_n} == 3'b111, "R1 strobes idle high in reset", int'({ras_n, cas_n, we_n}), 7);
    expect_refreshes(INIT);
    @(negedge clk);
    rst = 1'b0;
    rst_cyc = cyc;

    // start-up pause and burst
    while (!ready) @(negedge clk);
    #1;
    check(req_rise.size() >= 1 && req_rise[0] - rst_cyc >= PAUSE,
          "R2 no request during pause", req_rise[0] - rst_cyc, PAUSE);
    check(req_rise[0] - rst_cyc <= PAUSE + 3, "R2 request soon after pause", req_rise[0] - rst_cyc, PAUSE + 2);
    check(nref == INIT, "R3 start-up refresh count before ready", nref, INIT);
    check(drv_falls == 1, "R10 start-up burst under one grant", drv_falls, 1);

    // steady refresh, grant always on
    expect_refreshes(2);
    wait_cyc(ready_cyc + IVL + 5);
    check(req_rise.size() == 2, "R8 one request per interval", req_rise.size(), 2);
    check(req_rise[1] - ready_cyc == IVL + 1, "R8 first request after ready", req_rise[1] - ready_cyc, IVL + 1);
    check(ready == 1'b1, "R3 ready stays high", int'(ready), 1);
    wait_cyc(ready_cyc + 2*IVL + 40);
    check(req_rise.size() == 3 && req_rise[2] - req_rise[1] == IVL, "R8 request spacing",
          req_rise[2] - req_rise[1], IVL);

    // withheld grant: backlog builds and saturates
    wait_cyc(ready_cyc + 850);
    gnt = 1'b0;
    nb = nref;
    base = ready_cyc + 13*IVL + 2;
    wait_cyc(base);
    check(nref == nb, "R4 no refresh without grant", nref - nb, 0);
    check(req == 1'b1 && ras_n == 1'b1, "R4 request held, strobes idle", int'({req, ras_n}), 3);
    expect_refreshes(MAXB);
    df = drv_falls;
    gnt = 1'b1;
    wait_cyc(base + MAXB*(SETUP + TRAS + TRP) + 20);
    check(nref - nb == MAXB, "R10 backlog capped and drained", nref - nb, MAXB);
    check(drv_falls - df == 1, "R10 backlog run back to back", drv_falls - df, 1);
    check(req == 1'b0, "R10 request drops after last", int'(req), 0);

    // 4K variant default interval
    while (req2_cyc < 0) @(negedge clk);
    #1;
    check(req2_cyc - ready2_cyc == IVL4K + 1, "R9 derived interval 64ms/4096",
          req2_cyc - ready2_cyc, IVL4K + 1);
    check(expq.size() == 0, "R4 all expected refreshes seen", expq.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule